// File: doc/BRIEF.md
# Serial Port Interrupt and DMA Request Generator

This block turns the event pulses and FIFO fill levels of a serial peripheral into two interrupt lines and two DMA request lines. A single mode input picks between a single-buffer arrangement and a FIFO arrangement. In single-buffer mode, a receive overrun and a data-complete event each set a sticky flag. Both flags are merged onto the receive interrupt line. In FIFO mode, two comparisons of fill count against a programmed level drive a receive interrupt, a transmit interrupt and the two DMA requests.

Each sticky flag is gated by its own enable before it reaches a line. Software clears a flag by pulsing its acknowledge input. The FIFO storage, the shift engine, register decoding and the DMA controller sit outside this block. Every output comes from a register and is cleared by a synchronous active-high reset.

Top module: `spi_irq_dma_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all four outputs are 0 after that edge.
- R2: With `fifo_en`=0, a pulse on `ovr_evt` sets a sticky overrun flag. That flag stays set until it is acknowledged. When `ovr_ie`=1 it drives `rx_irq`=1.
- R3: With `fifo_en`=0, a pulse on either `rxw_evt` or `txe_evt` sets one shared sticky data-complete flag. When `xfer_ie`=1 it drives `rx_irq`=1.
- R4: A 1 on `ovr_ack` or `xfer_ack` clears the matching single-buffer flag. If a set event arrives in the same cycle, the set wins and the flag stays 1.
- R5: With `fifo_en`=1, the receive-level flag sets while `rx_count >= rx_level`. When `rxf_ie`=1 it alone drives `rx_irq`. Single-buffer events in FIFO mode set no flag.
- R6: With `fifo_en`=1, the transmit-level flag sets while `tx_count < tx_level`. When `txf_ie`=1 it drives `tx_irq`. `tx_irq` is 0 whenever `fifo_en`=0.
- R7: A FIFO level flag acknowledged while its condition still holds is cleared for one cycle and then sets again. This gives a one-cycle low pulse on its interrupt line.
- R8: `tx_dma_req` is 1 in the cycle after an edge at which `fifo_en`=1 and `tx_count < tx_level`. Otherwise it is 0.
- R9: `rx_dma_req` is 1 in the cycle after an edge at which `fifo_en`=1 and `rx_count >= rx_level`, including the full count 16 with a level of 16. Otherwise it is 0.
- R10: Both DMA requests are 0 in the cycle after any edge at which `fifo_en`=0, whatever the counts and levels.
- R11: Enables gate only the outputs. A flag set while its enable is 0 raises its interrupt one cycle after the enable goes to 1.
- R12: An event sampled at edge k sets its flag at edge k. The interrupt line rises at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 selects FIFO mode, 0 selects single-buffer mode |
| ovr_evt | input | 1 | Receive overrun pulse |
| rxw_evt | input | 1 | Received-word pulse |
| txe_evt | input | 1 | Transmit-buffer-empty pulse |
| tx_count | input | 5 | Transmit FIFO fill count, 0 to 16 |
| rx_count | input | 5 | Receive FIFO fill count, 0 to 16 |
| tx_level | input | 5 | Transmit threshold |
| rx_level | input | 5 | Receive threshold |
| ovr_ie | input | 1 | Overrun interrupt enable |
| xfer_ie | input | 1 | Data-complete interrupt enable |
| rxf_ie | input | 1 | Receive-level interrupt enable |
| txf_ie | input | 1 | Transmit-level interrupt enable |
| ovr_ack | input | 1 | Write-one clear for the overrun flag |
| xfer_ack | input | 1 | Write-one clear for the data-complete flag |
| rxf_ack | input | 1 | Write-one clear for the receive-level flag |
| txf_ack | input | 1 | Write-one clear for the transmit-level flag |
| rx_irq | output | 1 | Receive interrupt line |
| tx_irq | output | 1 | Transmit interrupt line |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The hardest situation to reach from the ports is the re-arm dip of a FIFO level flag. It only shows when an acknowledge lands while the level condition is still true. The result is a single low cycle on the interrupt line, two edges after the acknowledge. The stimulus holds the receive count above its level and pulses the acknowledge for one cycle. It then samples the line on three consecutive cycles to see it high, low and high again. The same-cycle set and acknowledge race on a single-buffer flag is reached by driving both inputs from one task on the same falling edge.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  // width needed to hold the values 0..depth inclusive
  function automatic int unsigned cnt_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/sticky_flag.sv
module sticky_flag #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic ack_i,
  output logic flag_o
);
  generate
    if (SET_WINS) begin : g_set_first
      always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (ack_i) flag_o <= 1'b0;
      end

      // R4
      set_beats_ack_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);
      // R4
      ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !set_i) |=> !flag_o);
    end else begin : g_ack_first
      always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (ack_i) flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
      end

      // R7
      ack_first_chk: assert property (@(posedge clk) disable iff (rst)
        ack_i |=> !flag_o);
      // R7
      rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (set_i && !ack_i) |=> flag_o);
    end
  endgenerate

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !ack_i) |=> flag_o);
endmodule

// File: rtl/level_cmp.sv
module level_cmp #(
  parameter int unsigned CW = 5,
  parameter bit AT_LEAST = 1'b0   // 1: count >= level, 0: count < level
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] level_i,
  output logic          hit_o,
  output logic          req_o
);
  generate
    if (AT_LEAST) begin : g_ge
      assign hit_o = (count_i >= level_i);
    end else begin : g_lt
      assign hit_o = (count_i < level_i);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) req_o <= 1'b0;
    else     req_o <= en_i & hit_o;
  end

  // R10
  dma_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !req_o);
  // R8
  dma_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && hit_o) |=> req_o);
endmodule

// File: rtl/irq_router.sv
module irq_router (
  input  logic clk,
  input  logic rst,
  input  logic fifo_en,
  input  logic ovr_flag,
  input  logic xfer_flag,
  input  logic rxf_flag,
  input  logic txf_flag,
  input  logic ovr_ie,
  input  logic xfer_ie,
  input  logic rxf_ie,
  input  logic txf_ie,
  output logic rx_irq,
  output logic tx_irq
);
  logic rx_legacy, rx_fifo, tx_fifo;

  always_comb begin
    rx_legacy = (ovr_flag & ovr_ie) | (xfer_flag & xfer_ie);
    rx_fifo   = rxf_flag & rxf_ie;
    tx_fifo   = txf_flag & txf_ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_irq <= 1'b0;
      tx_irq <= 1'b0;
    end else begin
      rx_irq <= fifo_en ? rx_fifo : rx_legacy;
      tx_irq <= fifo_en & tx_fifo;
    end
  end

  // R6
  tx_line_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |=> !tx_irq);
  // R11
  gated_off_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && !rxf_ie) |=> !rx_irq);
endmodule

// File: rtl/spi_irq_dma_gen.sv
module spi_irq_dma_gen
  import spi_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned CW = cnt_width(FIFO_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          ovr_evt,
  input  logic          rxw_evt,
  input  logic          txe_evt,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_level,
  input  logic [CW-1:0] rx_level,
  input  logic          ovr_ie,
  input  logic          xfer_ie,
  input  logic          rxf_ie,
  input  logic          txf_ie,
  input  logic          ovr_ack,
  input  logic          xfer_ack,
  input  logic          rxf_ack,
  input  logic          txf_ack,
  output logic          rx_irq,
  output logic          tx_irq,
  output logic          tx_dma_req,
  output logic          rx_dma_req
);
  logic ovr_set, xfer_set, rxf_set, txf_set;
  logic ovr_flag, xfer_flag, rxf_flag, txf_flag;
  logic rx_hit, tx_hit;

  always_comb begin
    ovr_set  = ~fifo_en & ovr_evt;
    xfer_set = ~fifo_en & (rxw_evt | txe_evt);
    rxf_set  = fifo_en & rx_hit;
    txf_set  = fifo_en & tx_hit;
  end

  level_cmp #(.CW(CW), .AT_LEAST(1'b0)) i_tx_cmp (
    .clk(clk), .rst(rst), .en_i(fifo_en),
    .count_i(tx_count), .level_i(tx_level),
    .hit_o(tx_hit), .req_o(tx_dma_req)
  );

  level_cmp #(.CW(CW), .AT_LEAST(1'b1)) i_rx_cmp (
    .clk(clk), .rst(rst), .en_i(fifo_en),
    .count_i(rx_count), .level_i(rx_level),
    .hit_o(rx_hit), .req_o(rx_dma_req)
  );

  sticky_flag #(.SET_WINS(1'b1)) i_ovr_flag (
    .clk(clk), .rst(rst), .set_i(ovr_set), .ack_i(ovr_ack), .flag_o(ovr_flag)
  );
  sticky_flag #(.SET_WINS(1'b1)) i_xfer_flag (
    .clk(clk), .rst(rst), .set_i(xfer_set), .ack_i(xfer_ack), .flag_o(xfer_flag)
  );
  sticky_flag #(.SET_WINS(1'b0)) i_rxf_flag (
    .clk(clk), .rst(rst), .set_i(rxf_set), .ack_i(rxf_ack), .flag_o(rxf_flag)
  );
  sticky_flag #(.SET_WINS(1'b0)) i_txf_flag (
    .clk(clk), .rst(rst), .set_i(txf_set), .ack_i(txf_ack), .flag_o(txf_flag)
  );

  irq_router i_router (
    .clk(clk), .rst(rst), .fifo_en(fifo_en),
    .ovr_flag(ovr_flag), .xfer_flag(xfer_flag),
    .rxf_flag(rxf_flag), .txf_flag(txf_flag),
    .ovr_ie(ovr_ie), .xfer_ie(xfer_ie), .rxf_ie(rxf_ie), .txf_ie(txf_ie),
    .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !(rx_irq || tx_irq || tx_dma_req || rx_dma_req));
  // R10
  no_dma_legacy_chk: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |=> !(tx_dma_req || rx_dma_req));
  // R5
  legacy_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_en |=> !$rose(ovr_flag) && !$rose(xfer_flag));
endmodule

// File: tb/test_spi_irq_dma_gen.sv
`timescale 1ns/1ps
module test_spi_irq_dma_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 0, ovr_evt = 0, rxw_evt = 0, txe_evt = 0;
  logic [4:0] tx_count = 0, rx_count = 0, tx_level = 0, rx_level = 0;
  logic ovr_ie = 0, xfer_ie = 0, rxf_ie = 0, txf_ie = 0;
  logic ovr_ack = 0, xfer_ack = 0, rxf_ack = 0, txf_ack = 0;
  logic rx_irq, tx_irq, tx_dma_req, rx_dma_req;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  spi_irq_dma_gen i_spi_irq_dma_gen (
    .clk(clk), .rst(rst), .fifo_en(fifo_en),
    .ovr_evt(ovr_evt), .rxw_evt(rxw_evt), .txe_evt(txe_evt),
    .tx_count(tx_count), .rx_count(rx_count),
    .tx_level(tx_level), .rx_level(rx_level),
    .ovr_ie(ovr_ie), .xfer_ie(xfer_ie), .rxf_ie(rxf_ie), .txf_ie(txf_ie),
    .ovr_ack(ovr_ack), .xfer_ack(xfer_ack), .rxf_ack(rxf_ack), .txf_ack(txf_ack),
    .rx_irq(rx_irq), .tx_irq(tx_irq),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic t_reset();
    step(3);
    check("R1 rx_irq", rx_irq, 1'b0);
    check("R1 tx_irq", tx_irq, 1'b0);
    check("R1 tx_dma", tx_dma_req, 1'b0);
    check("R1 rx_dma", rx_dma_req, 1'b0);
    rst = 1'b0;
    step(2);
  endtask

  task automatic t_legacy_ovr();
    ovr_ie = 1;
    ovr_evt = 1; step(); ovr_evt = 0;
    check("R12 irq not yet", rx_irq, 1'b0);
    step();
    check("R2 overrun irq", rx_irq, 1'b1);
    step(3);
    check("R2 sticky", rx_irq, 1'b1);
    check("R6 tx quiet", tx_irq, 1'b0);
    ovr_ack = 1; step(); ovr_ack = 0; step();
    check("R4 ack clears", rx_irq, 1'b0);
  endtask

  task automatic t_legacy_xfer();
    xfer_ie = 1;
    rxw_evt = 1; step(); rxw_evt = 0; step();
    check("R3 rx word", rx_irq, 1'b1);
    xfer_ack = 1; step(); xfer_ack = 0; step();
    check("R3 cleared", rx_irq, 1'b0);
    txe_evt = 1; step(); txe_evt = 0; step();
    check("R3 tx empty", rx_irq, 1'b1);
    xfer_ack = 1; step(); xfer_ack = 0; step();
    check("R3 cleared again", rx_irq, 1'b0);
  endtask

  task automatic t_set_wins();
    rxw_evt = 1; xfer_ack = 1; step(); rxw_evt = 0; xfer_ack = 0; step();
    check("R4 set beats ack", rx_irq, 1'b1);
    step(2);
    check("R4 still set", rx_irq, 1'b1);
    xfer_ack = 1; step(); xfer_ack = 0; step();
    check("R4 cleared", rx_irq, 1'b0);
  endtask

  task automatic t_enable_gate();
    ovr_ie = 0;
    ovr_evt = 1; step(); ovr_evt = 0; step(2);
    check("R11 masked", rx_irq, 1'b0);
    ovr_ie = 1; step();
    check("R11 late enable", rx_irq, 1'b1);
    ovr_ack = 1; step(); ovr_ack = 0; step();
    check("R11 cleared", rx_irq, 1'b0);
  endtask

  task automatic t_fifo_rx();
    rx_level = 4; rx_count = 3; tx_level = 0; tx_count = 0; rxf_ie = 1;
    step();
    fifo_en = 1;
    ovr_evt = 1; rxw_evt = 1; step(); ovr_evt = 0; rxw_evt = 0; step(2);
    check("R5 legacy ignored", rx_irq, 1'b0);
    check("R9 below level", rx_dma_req, 1'b0);
    rx_count = 4; step();
    check("R9 at level", rx_dma_req, 1'b1);
    step();
    check("R5 rx level irq", rx_irq, 1'b1);
    rx_count = 16; rx_level = 16; step();
    check("R9 full count", rx_dma_req, 1'b1);
    rxf_ack = 1; step(); rxf_ack = 0;
    check("R7 before dip", rx_irq, 1'b1);
    step();
    check("R7 dip", rx_irq, 1'b0);
    step();
    check("R7 rearmed", rx_irq, 1'b1);
    rx_count = 15; step();
    check("R9 under full", rx_dma_req, 1'b0);
    rxf_ack = 1; step(); rxf_ack = 0; step(2);
    check("R5 cleared", rx_irq, 1'b0);
  endtask

  task automatic t_fifo_tx();
    tx_level = 8; tx_count = 8; step(2);
    check("R8 equal no req", tx_dma_req, 1'b0);
    check("R6 no irq", tx_irq, 1'b0);
    tx_count = 7; step();
    check("R8 below level", tx_dma_req, 1'b1);
    step();
    check("R6 masked", tx_irq, 1'b0);
    txf_ie = 1; step();
    check("R6 tx irq", tx_irq, 1'b1);
    tx_count = 16; tx_level = 16; step();
    check("R8 full", tx_dma_req, 1'b0);
    txf_ack = 1; step(); txf_ack = 0; step(2);
    check("R6 cleared", tx_irq, 1'b0);
  endtask

  task automatic t_fifo_off();
    tx_level = 8; tx_count = 0; rx_level = 4; rx_count = 16; step(3);
    check("R8 pre", tx_dma_req, 1'b1);
    check("R6 pre", tx_irq, 1'b1);
    fifo_en = 0; step();
    check("R10 tx dma", tx_dma_req, 1'b0);
    check("R10 rx dma", rx_dma_req, 1'b0);
    check("R6 tx irq off", tx_irq, 1'b0);
    step();
    check("R5 no legacy carry", rx_irq, 1'b0);
  endtask

  initial begin
    t_reset();
    t_legacy_ovr();
    t_legacy_xfer();
    t_set_wins();
    t_enable_gate();
    t_fifo_rx();
    t_fifo_tx();
    t_fifo_off();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule